// File: doc/BRIEF.md
# UART Bit-Timing Generator with Per-Bit Width Trim

This block produces the bit timing for one direction of a UART that oversamples each bit 16 times. An integer divisor sets how long one oversampling period lasts. On top of that, every bit slot in the frame can be made one oversampling period longer or shorter. With the right pattern of longer and shorter bits, the total length of a frame tracks a baud rate that the divisor alone cannot reach, and the error no longer builds up from bit to bit.

A serializer, or a receiver that has found a start edge, pulses `frame_start` while the generator is idle. The generator then captures the divisor, the trim word and the frame shape, and raises `busy`. For each bit it pulses `bit_end` on that bit's last clock cycle and reports the bit's position in `bit_idx`. After the last bit it drops `busy`. The transmit and receive paths each use their own instance. Both instances take the same divisor, and each takes its own trim word.

Top module: `ubg_baud_gen`

## Requirements
- R1: While reset is held, and until the first frame starts, `busy` is 0, `bit_idx` is 0 and `bit_end` is 0.
- R2: A `frame_start` sampled high while `busy` is 0 makes `busy` 1 and `bit_idx` 0 in the next cycle. A `frame_start` sampled while `busy` is 1 is ignored, so the current frame's timing does not change.
- R3: With trim code 00, a bit lasts exactly 16 × (`div_reg` + 1) clock cycles. `bit_end` is high only in the last cycle of each bit.
- R4: Bit position i takes its trim code from `trim_word[2i+1:2i]`. Code 01 lengthens the bit to 17 × (`div_reg` + 1) cycles. Code 10 shortens it to 15 × (`div_reg` + 1) cycles. Code 11 acts the same as code 00.
- R5: The frame holds 1 + (`data_len` + 5) + (1 if `parity_mode` ≠ 0, else 0) + (`stop_sel` + 1) bits. `busy` falls in the cycle after the `bit_end` of the last bit.
- R6: Trim fields for bit positions at or beyond the configured frame length have no effect on timing.
- R7: `div_reg`, `trim_word`, `data_len`, `parity_mode` and `stop_sel` are captured when a frame starts. Changing them while `busy` is 1 does not affect the frame in progress.
- R8: `bit_idx` starts at 0 and rises by exactly one after each `bit_end`, except after the last bit. It holds its value between bit ends and returns to 0 when the frame ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Request to begin a frame; honoured only when idle |
| div_reg | input | DIV_W | Divisor minus one |
| trim_word | input | 2*MAX_BITS | Two-bit trim code per bit position |
| data_len | input | 2 | Data bits minus five |
| parity_mode | input | 3 | 0 means no parity bit; any other value adds one bit |
| stop_sel | input | 1 | Stop bits minus one |
| busy | output | 1 | A frame is in progress |
| bit_idx | output | IDX_W | Position of the current bit within the frame |
| bit_end | output | 1 | Pulses in the last cycle of each bit |

## Verification
A wrong internal count is visible at the ports within one bit time. If the oversampling or sub-bit counter is off, the first `bit_end` comes early or late by whole cycles. If the trim code is taken from the wrong bit position, the error shows up at the end of the first bit whose code differs from the intended one. If the captured frame length is wrong, the error appears at the end of the frame: `busy` falls one or more bit times away from the expected cycle. The reference model compares `busy`, `bit_idx` and `bit_end` on every clock, so the first cycle of any drift is reported. A separate check of each frame's total length gives a second, independent figure.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

  // Longest frame: start + 8 data + parity + 2 stop
  localparam int MAX_BITS = 12;
  localparam int IDX_W    = $clog2(MAX_BITS);
  localparam int LEN_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {
    TRIM_NONE = 2'b00,
    TRIM_LONG = 2'b01,
    TRIM_SHORT = 2'b10,
    TRIM_RSVD = 2'b11
  } trim_code_e;

  // Oversampling periods in one bit for a given trim code
  function automatic int periods_per_bit(input logic [1:0] code, input int osr);
    case (trim_code_e'(code))
      TRIM_LONG:  return osr + 1;
      TRIM_SHORT: return osr - 1;
      default:    return osr;
    endcase
  endfunction

  // Total bits in a frame from the shape fields
  function automatic int frame_bits(input logic [1:0] dlen, input logic [2:0] par,
                                    input logic stop);
    return 1 + (int'(dlen) + 5) + ((par != 3'd0) ? 1 : 0) + (int'(stop) + 1);
  endfunction

endpackage

// File: rtl/ubg_prescale.sv
module ubg_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_q,
  output logic             sub_tick
);

  logic [DIV_W-1:0] cnt;

  assign sub_tick = run && (cnt == div_q);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || sub_tick) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ubg_bit_timer.sv
module ubg_bit_timer
  import ubg_pkg::*;
#(
  parameter int OSR = 16,
  localparam int SUB_W = $clog2(OSR + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       sub_tick,
  input  logic [1:0] code,
  output logic       bit_end
);

  logic [SUB_W-1:0] sub_cnt;
  logic [SUB_W-1:0] limit;

  assign limit   = SUB_W'(periods_per_bit(code, OSR));
  assign bit_end = sub_tick && (sub_cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) sub_cnt <= '0;
    else if (sub_tick)  sub_cnt <= bit_end ? '0 : sub_cnt + 1'b1;
  end

endmodule

// File: rtl/ubg_frame_seq.sv
module ubg_frame_seq
  import ubg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic [DIV_W-1:0]      div_in,
  input  logic [2*MAX_BITS-1:0] trim_in,
  input  logic [1:0]            dlen,
  input  logic [2:0]            par,
  input  logic                  stop,
  input  logic                  bit_end,
  output logic                  busy,
  output logic [IDX_W-1:0]      bit_idx,
  output logic [DIV_W-1:0]      div_q,
  output logic [1:0]            code,
  output logic [LEN_W-1:0]      len_q,
  output logic                  start_ok,
  output logic                  last_bit
);

  logic [2*MAX_BITS-1:0] trim_q;

  assign start_ok = frame_start && !busy;
  assign code     = trim_q[{bit_idx, 1'b0} +: 2];
  assign last_bit = bit_end && (LEN_W'(bit_idx) == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      div_q   <= '0;
      trim_q  <= '0;
      len_q   <= '0;
    end else if (start_ok) begin
      busy    <= 1'b1;
      bit_idx <= '0;
      div_q   <= div_in;
      trim_q  <= trim_in;
      len_q   <= LEN_W'(frame_bits(dlen, par, stop));
    end else if (last_bit) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else if (bit_end) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

endmodule

// File: rtl/ubg_baud_gen.sv
module ubg_baud_gen
  import ubg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OSR   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic [DIV_W-1:0]      div_reg,
  input  logic [2*MAX_BITS-1:0] trim_word,
  input  logic [1:0]            data_len,
  input  logic [2:0]            parity_mode,
  input  logic                  stop_sel,
  output logic                  busy,
  output logic [IDX_W-1:0]      bit_idx,
  output logic                  bit_end
);

  // Internal events, named for the checker
  logic             sub_tick;
  logic             last_bit;
  logic             start_ok;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;
  logic [1:0]       code;

  ubg_frame_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .div_in(div_reg), .trim_in(trim_word), .dlen(data_len),
    .par(parity_mode), .stop(stop_sel), .bit_end(bit_end),
    .busy(busy), .bit_idx(bit_idx), .div_q(div_q), .code(code),
    .len_q(len_q), .start_ok(start_ok), .last_bit(last_bit)
  );

  ubg_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_q(div_q), .sub_tick(sub_tick)
  );

  ubg_bit_timer #(.OSR(OSR)) u_bit (
    .clk(clk), .rst_n(rst_n), .run(busy), .sub_tick(sub_tick),
    .code(code), .bit_end(bit_end)
  );

endmodule

// File: rtl/ubg_baud_gen_chk.sv
module ubg_baud_gen_chk
  import ubg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             busy,
  input logic [IDX_W-1:0] bit_idx,
  input logic             bit_end,
  input logic             sub_tick,
  input logic             last_bit,
  input logic             start_ok,
  input logic [DIV_W-1:0] div_q,
  input logic [LEN_W-1:0] len_q
);

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy && (bit_idx == '0));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && busy && !last_bit |=> busy);

  // R3
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_tick |-> busy);

  // R3
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> sub_tick);

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (LEN_W'(bit_idx) < len_q));

  // R5
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> !busy);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> $stable(div_q) && $stable(len_q));

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_end |=> $stable(bit_idx));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bit_idx == '0));

endmodule

bind ubg_baud_gen ubg_baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .busy(busy),
  .bit_idx(bit_idx), .bit_end(bit_end), .sub_tick(sub_tick),
  .last_bit(last_bit), .start_ok(start_ok), .div_q(div_q), .len_q(len_q)
);

// File: tb/tb_ubg_baud_gen.sv
module tb_ubg_baud_gen;

  localparam int NB = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [7:0]    div_reg = '0;
  logic [2*NB-1:0] trim_word = '0;
  logic [1:0]    data_len = '0;
  logic [2:0]    parity_mode = '0;
  logic          stop_sel = 1'b0;
  logic          busy;
  logic [3:0]    bit_idx;
  logic          bit_end;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  ubg_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .div_reg(div_reg),
    .trim_word(trim_word), .data_len(data_len), .parity_mode(parity_mode),
    .stop_sel(stop_sel), .busy(busy), .bit_idx(bit_idx), .bit_end(bit_end)
  );

  // Behavioural reference model
  int m_act, m_idx, m_cyc, m_div, m_len, m_total;
  logic [2*NB-1:0] m_trim;

  function automatic int width_of(int dv, logic [2*NB-1:0] tw, int i);
    int base;
    base = 16;
    if (tw[2*i +: 2] == 2'b01) base = 17;
    if (tw[2*i +: 2] == 2'b10) base = 15;
    return (dv + 1) * base;
  endfunction

  function automatic int len_of(logic [1:0] dl, logic [2:0] pm, logic sb);
    return 2 + (dl + 5) + (pm != 0 ? 1 : 0) + sb;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_idx = 0; m_cyc = 0;
    end else if (m_act == 0) begin
      if (frame_start) begin
        m_act = 1; m_idx = 0; m_cyc = 0;
        m_div = div_reg; m_trim = trim_word;
        m_len = len_of(data_len, parity_mode, stop_sel);
        m_total = 0;
        for (int i = 0; i < m_len; i++) m_total += width_of(m_div, m_trim, i);
      end
    end else if (m_cyc == width_of(m_div, m_trim, m_idx) - 1) begin
      m_cyc = 0;
      if (m_idx == m_len - 1) begin m_act = 0; m_idx = 0; end
      else m_idx++;
    end else begin
      m_cyc++;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison and frame-length measurement
  int run_cnt = 0;
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    int eb;
    eb = (m_act != 0 && m_cyc == width_of(m_div, m_trim, m_idx) - 1) ? 1 : 0;
    check("R5", "busy", int'(busy), m_act);
    check("R8", "bit_idx", int'(bit_idx), m_idx);
    check("R4", "bit_end", int'(bit_end), eb);
    if (busy) run_cnt++;
    if (prev_busy && !busy) begin
      check("R3", "frame cycles", run_cnt, m_total);
      run_cnt = 0;
    end
    prev_busy = busy;
  end

  task automatic frame(input logic [7:0] dv, input logic [2*NB-1:0] tw,
                       input logic [1:0] dl, input logic [2:0] pm, input logic sb);
    @(negedge clk);
    div_reg = dv; trim_word = tw; data_len = dl; parity_mode = pm; stop_sel = sb;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset bit_idx", int'(bit_idx), 0);
    check("R1", "reset bit_end", int'(bit_end), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "idle busy", int'(busy), 0);

    // R3: nominal timing, 5 data, no parity, 1 stop (7 bits)
    frame(8'd0, '0, 2'd0, 3'd0, 1'b0);
    // R4: alternating long/short, 8 data, parity, 2 stop (12 bits)
    frame(8'd2, {6{4'b1001}}, 2'd3, 3'd2, 1'b1);
    // R4: code 11 behaves as 00
    frame(8'd1, {NB{2'b11}}, 2'd2, 3'd0, 1'b0);
    // R6: long codes above a 7-bit frame only
    frame(8'd1, {{5{2'b01}}, {7{2'b00}}}, 2'd0, 3'd0, 1'b0);
    // R5: every parity option adds one bit
    frame(8'd0, '0, 2'd1, 3'd4, 1'b0);
    frame(8'd3, {NB{2'b10}}, 2'd3, 3'd0, 1'b1);

    // R7 and R2: change config and re-request mid-frame
    @(negedge clk);
    div_reg = 8'd1; trim_word = {NB{2'b01}}; data_len = 2'd1; parity_mode = 3'd0; stop_sel = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (20) @(negedge clk);
    div_reg = 8'd5; trim_word = {NB{2'b10}}; data_len = 2'd3; parity_mode = 3'd1; stop_sel = 1'b1;
    frame_start = 1'b1;  // R2: ignored while busy
    @(negedge clk);
    check("R2", "busy held on re-request", int'(busy), 1);
    frame_start = 1'b0;
    while (busy) @(negedge clk);

    // R2: back-to-back, start on the first idle cycle
    frame(8'd0, {NB{2'b01}}, 2'd0, 3'd0, 1'b0);
    frame(8'd0, {NB{2'b10}}, 2'd0, 3'd3, 1'b1);
    // Larger divisor
    frame(8'd9, {3'b0, 21'h0, 2'b01, 2'b10}, 2'd3, 3'd0, 1'b0);

    repeat (5) @(negedge clk);
    check("R8", "idle bit_idx", int'(bit_idx), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule